// File: doc/BRIEF.md
# SMBus Control and Status Flag Controller

This block keeps the hardware-maintained flag bits of a two-wire serial port that speaks SMBus and I2C. A separate bus engine samples SCL and SDA, shifts the bits and compares slave addresses. It reports to this block through single-cycle event strobes. Those strobes report a START or STOP the port generated itself, a START or STOP seen on the bus, an address match, a received byte, the end of an acknowledge cycle together with the sampled SDA level, the start of a frame, a write to the data register, and two clock or data conflicts. From these strobes the block derives the port's role (master or slave, transmitter or receiver), the START and STOP request bits, the acknowledge-needed and acknowledge bits, the arbitration-fault bit, the interrupt flag and the gated interrupt request.

Software reaches the four writable bits through a one-cycle write strobe that carries a value for each bit. The writable bits are the START request, the STOP request, the acknowledge bit and the interrupt flag. The role bits, acknowledge-needed and arbitration-fault are read-only.

The role is held by a four-state machine: ROLE_SLV_RX, ROLE_SLV_TX, ROLE_MST_RX and ROLE_MST_TX. Its transitions are taken in priority order:
- arbitration loss goes to ROLE_SLV_RX;
- a generated START goes to ROLE_MST_TX;
- a generated STOP goes from a master state to the slave state of the same direction;
- a detected START goes to the receive state of the current role;
- a frame begin goes to the transmit state of the current role if the data register was written since the last frame begin, and to the receive state otherwise.

A second, two-state machine tracks whether the port is addressed as a slave. It moves from LINK_IDLE to LINK_ADDRESSED on an address match. It returns to LINK_IDLE on a detected STOP, or on a detected START that comes without an address match.

Top module: `smb_flag_ctrl`

## Requirements
- R1: Synchronous reset clears every flag output and `irq` on the next clock edge.
- R2: `ev_start_gen` sets `is_master`, `tx_dir` and `irq_flag` on the next edge.
- R3: `ev_stop_gen` clears `is_master` and `stop_req`. Any arbitration loss clears both `is_master` and `tx_dir`.
- R4: At `ev_frame_begin`, `tx_dir` becomes 1 if `ev_dat_wr` pulsed since the previous frame begin (the same cycle counts), and 0 otherwise. A detected START (`ev_start_det`) clears `tx_dir`.
- R5: `ev_addr_match` sets `start_req` and `irq_flag`. Only a software write of 0 clears `start_req`.
- R6: `ev_stop_det` while addressed as a slave sets `stop_req` and `irq_flag`. While neither addressed nor master, it changes no output.
- R7: `ev_stop_det` as master without `ev_stop_gen` in the same cycle is an arbitration loss. It sets `stop_req` and `irq_flag`, clears the role bits and leaves `arb_fault` unchanged.
- R8: `arb_fault` sets on any of three strobes: `ev_start_det` while master with `start_req`=0, `ev_scl_low_ctl`, or `ev_sda_low_one`. Each of them also sets `irq_flag` and clears the role. `ev_start_det` while master with `start_req`=1 is not a fault.
- R9: `irq_flag` is cleared only by a software write of 0. `arb_fault` clears exactly when that write actually clears `irq_flag`, and a write of 1 leaves it set.
- R10: `ev_byte_rx` sets `ack_need` and `irq_flag`. `ev_ack_cycle` clears `ack_need`, and a same-cycle `ev_byte_rx` wins.
- R11: `ev_ack_cycle` while `tx_dir`=1 loads `ack_bit` with the inverse of `ack_line` (low means acknowledged) and sets `irq_flag`. While `tx_dir`=0 it changes neither bit.
- R12: For the same flag in the same cycle, a hardware set wins over a software write, and a software write wins over a hardware clear. The exception is `ack_bit`, where the hardware load always wins.
- R13: `irq` equals `irq_flag` AND `irq_en` and stays asserted until software clears `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_start_gen | input | 1 | Port generated a START or repeated START |
| ev_stop_gen | input | 1 | Port generated a STOP |
| ev_start_det | input | 1 | START seen on the bus |
| ev_stop_det | input | 1 | STOP seen on the bus |
| ev_addr_match | input | 1 | START plus matching address and R/W received |
| ev_byte_rx | input | 1 | Data byte received |
| ev_ack_cycle | input | 1 | Acknowledge cycle finished |
| ack_line | input | 1 | SDA level sampled in the acknowledge cycle |
| ev_frame_begin | input | 1 | A new frame is starting |
| ev_dat_wr | input | 1 | Data register written |
| ev_scl_low_ctl | input | 1 | SCL low while generating STOP or repeated START |
| ev_sda_low_one | input | 1 | SDA low while sending a 1 data bit |
| sw_wr | input | 1 | Software write strobe |
| sw_start | input | 1 | Written value of the START request |
| sw_stop | input | 1 | Written value of the STOP request |
| sw_ack | input | 1 | Written value of the acknowledge bit |
| sw_irq | input | 1 | Written value of the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| is_master | output | 1 | Port is bus master |
| tx_dir | output | 1 | Port is transmitter |
| start_req | output | 1 | START request bit |
| stop_req | output | 1 | STOP request bit |
| ack_need | output | 1 | Acknowledge response needed |
| arb_fault | output | 1 | Arbitration lost |
| ack_bit | output | 1 | Acknowledge bit |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones that depend on hidden state: the addressed-slave link state and the record of a data write before a frame. The first decides whether a bus STOP sets `stop_req`, and the second decides what `tx_dir` becomes at a frame begin. The stimulus reaches them by first sending an address match, or a data-register write, so that the state is set. It then issues the strobe that depends on it, and repeats the same strobe once the state has been consumed, to confirm it now has no effect. Same-cycle collisions are driven on purpose:
- a software clear together with a hardware set;
- a software write together with a hardware clear;
- a received byte together with an acknowledge cycle;
- a conflict strobe together with an interrupt-flag clear.

// File: rtl/smb_flag_pkg.sv
package smb_flag_pkg;

    // Role encoding: bit 1 = master, bit 0 = transmitter
    typedef enum logic [1:0] {
        ROLE_SLV_RX = 2'b00,
        ROLE_SLV_TX = 2'b01,
        ROLE_MST_RX = 2'b10,
        ROLE_MST_TX = 2'b11
    } role_t;

    typedef enum logic {
        LINK_IDLE      = 1'b0,
        LINK_ADDRESSED = 1'b1
    } link_t;

    // Index of each set/clear flag inside the flag vector
    localparam int F_SI  = 0;
    localparam int F_ACK = 1;
    localparam int F_ARB = 2;
    localparam int F_ARQ = 3;
    localparam int F_STO = 4;
    localparam int F_STA = 5;
    localparam int NUM_FLAGS = 6;

endpackage

// File: rtl/smb_flag_cell.sv
module smb_flag_cell #(
    parameter bit CLR_OVER_SW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic sw_we,
    input  logic sw_d,
    output logic q
);

    // Priority: hardware set, then (optionally) hardware clear, then software, then hardware clear
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (hw_set)
            q <= 1'b1;
        else if (CLR_OVER_SW && hw_clr)
            q <= 1'b0;
        else if (sw_we)
            q <= sw_d;
        else if (hw_clr)
            q <= 1'b0;
    end

endmodule

// File: rtl/smb_arb_monitor.sv
module smb_arb_monitor
    import smb_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_start_det,
    input  logic ev_stop_det,
    input  logic ev_stop_gen,
    input  logic ev_addr_match,
    input  logic ev_scl_low_ctl,
    input  logic ev_sda_low_one,
    input  logic master,
    input  logic start_req,
    output logic fault_set,
    output logic arb_lost,
    output logic stop_loss,
    output logic slave_stop
);

    link_t link_q, link_d;

    always_ff @(posedge clk) begin
        if (rst)
            link_q <= LINK_IDLE;
        else
            link_q <= link_d;
    end

    always_comb begin
        link_d = link_q;
        unique case (link_q)
            LINK_IDLE:
                if (ev_addr_match)
                    link_d = LINK_ADDRESSED;
            LINK_ADDRESSED:
                if (ev_addr_match)
                    link_d = LINK_ADDRESSED;
                else if (ev_stop_det || ev_start_det)
                    link_d = LINK_IDLE;
        endcase
    end

    logic rep_conflict;

    always_comb begin
        rep_conflict = ev_start_det && master && !start_req;
        fault_set    = rep_conflict || ev_scl_low_ctl || ev_sda_low_one;
        stop_loss    = ev_stop_det && master && !ev_stop_gen;
        arb_lost     = fault_set || stop_loss;
        slave_stop   = ev_stop_det && (link_q == LINK_ADDRESSED);
    end

endmodule

// File: rtl/smb_role_fsm.sv
module smb_role_fsm
    import smb_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arb_lost,
    input  logic ev_start_gen,
    input  logic ev_stop_gen,
    input  logic ev_start_det,
    input  logic ev_frame_begin,
    input  logic ev_dat_wr,
    output logic master,
    output logic tx
);

    role_t role_q, role_d;
    logic  wrote_q;
    logic  wrote_any;

    assign wrote_any = wrote_q || ev_dat_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            role_q  <= ROLE_SLV_RX;
            wrote_q <= 1'b0;
        end else begin
            role_q <= role_d;
            if (ev_frame_begin)
                wrote_q <= 1'b0;
            else if (ev_dat_wr)
                wrote_q <= 1'b1;
        end
    end

    always_comb begin
        role_d = role_q;
        if (arb_lost)
            role_d = ROLE_SLV_RX;
        else if (ev_start_gen)
            role_d = ROLE_MST_TX;
        else begin
            unique case (role_q)
                ROLE_MST_TX, ROLE_MST_RX: begin
                    if (ev_stop_gen)
                        role_d = (role_q == ROLE_MST_TX) ? ROLE_SLV_TX : ROLE_SLV_RX;
                    else if (ev_start_det)
                        role_d = ROLE_MST_RX;
                    else if (ev_frame_begin)
                        role_d = wrote_any ? ROLE_MST_TX : ROLE_MST_RX;
                end
                ROLE_SLV_TX, ROLE_SLV_RX: begin
                    if (ev_start_det)
                        role_d = ROLE_SLV_RX;
                    else if (ev_frame_begin)
                        role_d = wrote_any ? ROLE_SLV_TX : ROLE_SLV_RX;
                end
            endcase
        end
    end

    always_comb begin
        unique case (role_q)
            ROLE_SLV_RX: begin master = 1'b0; tx = 1'b0; end
            ROLE_SLV_TX: begin master = 1'b0; tx = 1'b1; end
            ROLE_MST_RX: begin master = 1'b1; tx = 1'b0; end
            ROLE_MST_TX: begin master = 1'b1; tx = 1'b1; end
        endcase
    end

endmodule

// File: rtl/smb_flag_bits.sv
module smb_flag_bits
    import smb_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx,
    input  logic ev_start_gen,
    input  logic ev_stop_gen,
    input  logic ev_addr_match,
    input  logic ev_byte_rx,
    input  logic ev_ack_cycle,
    input  logic ack_line,
    input  logic fault_set,
    input  logic arb_lost,
    input  logic stop_loss,
    input  logic slave_stop,
    input  logic sw_wr,
    input  logic sw_start,
    input  logic sw_stop,
    input  logic sw_ack,
    input  logic sw_irq,
    output logic [NUM_FLAGS-1:0] flags
);

    logic [NUM_FLAGS-1:0] set_v, clr_v, we_v, d_v;
    logic si_set, ack_tx;

    always_comb begin
        ack_tx = ev_ack_cycle && tx;
        si_set = ev_start_gen || arb_lost || ack_tx || ev_byte_rx
                 || ev_addr_match || slave_stop;

        set_v = '0;
        clr_v = '0;
        we_v  = '0;
        d_v   = '0;

        set_v[F_SI]  = si_set;
        we_v[F_SI]   = sw_wr;
        d_v[F_SI]    = sw_irq;

        set_v[F_ACK] = ack_tx && !ack_line;
        clr_v[F_ACK] = ack_tx && ack_line;
        we_v[F_ACK]  = sw_wr;
        d_v[F_ACK]   = sw_ack;

        set_v[F_ARB] = fault_set;
        clr_v[F_ARB] = sw_wr && !sw_irq && flags[F_SI] && !si_set;

        set_v[F_ARQ] = ev_byte_rx;
        clr_v[F_ARQ] = ev_ack_cycle;

        set_v[F_STO] = slave_stop || stop_loss;
        clr_v[F_STO] = ev_stop_gen;
        we_v[F_STO]  = sw_wr;
        d_v[F_STO]   = sw_stop;

        set_v[F_STA] = ev_addr_match;
        we_v[F_STA]  = sw_wr;
        d_v[F_STA]   = sw_start;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
        smb_flag_cell #(
            .CLR_OVER_SW(i == F_ACK)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .hw_set (set_v[i]),
            .hw_clr (clr_v[i]),
            .sw_we  (we_v[i]),
            .sw_d   (d_v[i]),
            .q      (flags[i])
        );
    end

endmodule

// File: rtl/smb_flag_ctrl.sv
module smb_flag_ctrl
    import smb_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_start_gen,
    input  logic ev_stop_gen,
    input  logic ev_start_det,
    input  logic ev_stop_det,
    input  logic ev_addr_match,
    input  logic ev_byte_rx,
    input  logic ev_ack_cycle,
    input  logic ack_line,
    input  logic ev_frame_begin,
    input  logic ev_dat_wr,
    input  logic ev_scl_low_ctl,
    input  logic ev_sda_low_one,
    input  logic sw_wr,
    input  logic sw_start,
    input  logic sw_stop,
    input  logic sw_ack,
    input  logic sw_irq,
    input  logic irq_en,
    output logic is_master,
    output logic tx_dir,
    output logic start_req,
    output logic stop_req,
    output logic ack_need,
    output logic arb_fault,
    output logic ack_bit,
    output logic irq_flag,
    output logic irq
);

    logic fault_set, arb_lost, stop_loss, slave_stop;
    logic master_w, tx_w;
    logic [NUM_FLAGS-1:0] flags;

    smb_arb_monitor u_arb (
        .clk            (clk),
        .rst            (rst),
        .ev_start_det   (ev_start_det),
        .ev_stop_det    (ev_stop_det),
        .ev_stop_gen    (ev_stop_gen),
        .ev_addr_match  (ev_addr_match),
        .ev_scl_low_ctl (ev_scl_low_ctl),
        .ev_sda_low_one (ev_sda_low_one),
        .master         (master_w),
        .start_req      (flags[F_STA]),
        .fault_set      (fault_set),
        .arb_lost       (arb_lost),
        .stop_loss      (stop_loss),
        .slave_stop     (slave_stop)
    );

    smb_role_fsm u_role (
        .clk            (clk),
        .rst            (rst),
        .arb_lost       (arb_lost),
        .ev_start_gen   (ev_start_gen),
        .ev_stop_gen    (ev_stop_gen),
        .ev_start_det   (ev_start_det),
        .ev_frame_begin (ev_frame_begin),
        .ev_dat_wr      (ev_dat_wr),
        .master         (master_w),
        .tx             (tx_w)
    );

    smb_flag_bits u_bits (
        .clk           (clk),
        .rst           (rst),
        .tx            (tx_w),
        .ev_start_gen  (ev_start_gen),
        .ev_stop_gen   (ev_stop_gen),
        .ev_addr_match (ev_addr_match),
        .ev_byte_rx    (ev_byte_rx),
        .ev_ack_cycle  (ev_ack_cycle),
        .ack_line      (ack_line),
        .fault_set     (fault_set),
        .arb_lost      (arb_lost),
        .stop_loss     (stop_loss),
        .slave_stop    (slave_stop),
        .sw_wr         (sw_wr),
        .sw_start      (sw_start),
        .sw_stop       (sw_stop),
        .sw_ack        (sw_ack),
        .sw_irq        (sw_irq),
        .flags         (flags)
    );

    assign is_master = master_w;
    assign tx_dir    = tx_w;
    assign start_req = flags[F_STA];
    assign stop_req  = flags[F_STO];
    assign ack_need  = flags[F_ARQ];
    assign arb_fault = flags[F_ARB];
    assign ack_bit   = flags[F_ACK];
    assign irq_flag  = flags[F_SI];
    assign irq       = flags[F_SI] && irq_en;

endmodule

// File: rtl/smb_flag_ctrl_chk.sv
module smb_flag_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ev_start_gen,
    input logic ev_start_det,
    input logic ev_stop_det,
    input logic ev_byte_rx,
    input logic ev_scl_low_ctl,
    input logic ev_sda_low_one,
    input logic sw_wr,
    input logic sw_start,
    input logic sw_irq,
    input logic is_master,
    input logic tx_dir,
    input logic start_req,
    input logic stop_req,
    input logic ack_need,
    input logic arb_fault,
    input logic ack_bit,
    input logic irq_flag,
    input logic irq
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !(is_master || tx_dir || start_req || stop_req || ack_need
                  || arb_fault || ack_bit || irq_flag || irq));

    p_start_gen_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_start_gen && !ev_start_det && !ev_stop_det && !ev_scl_low_ctl && !ev_sda_low_one)
        |=> (is_master && tx_dir && irq_flag));

    p_sta_sw_only_r5: assert property (@(posedge clk) disable iff (rst)
        (start_req && !(sw_wr && !sw_start)) |=> start_req);

    p_fault_set_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_scl_low_ctl || ev_sda_low_one) |=> (arb_fault && !is_master && irq_flag));

    p_arb_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(arb_fault) |-> $fell(irq_flag));

    p_si_sw_only_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !(sw_wr && !sw_irq)) |=> irq_flag);

    p_ackrq_set_r10: assert property (@(posedge clk) disable iff (rst)
        ev_byte_rx |=> (ack_need && irq_flag));

    p_irq_gate_r13: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_flag);

endmodule

bind smb_flag_ctrl smb_flag_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_start_gen   (ev_start_gen),
    .ev_start_det   (ev_start_det),
    .ev_stop_det    (ev_stop_det),
    .ev_byte_rx     (ev_byte_rx),
    .ev_scl_low_ctl (ev_scl_low_ctl),
    .ev_sda_low_one (ev_sda_low_one),
    .sw_wr          (sw_wr),
    .sw_start       (sw_start),
    .sw_irq         (sw_irq),
    .is_master      (is_master),
    .tx_dir         (tx_dir),
    .start_req      (start_req),
    .stop_req       (stop_req),
    .ack_need       (ack_need),
    .arb_fault      (arb_fault),
    .ack_bit        (ack_bit),
    .irq_flag       (irq_flag),
    .irq            (irq)
);

// File: tb/smb_flag_ctrl_bench.sv
module smb_flag_ctrl_bench;

    logic clk = 1'b0;
    logic rst;
    logic ev_start_gen, ev_stop_gen, ev_start_det, ev_stop_det, ev_addr_match;
    logic ev_byte_rx, ev_ack_cycle, ack_line, ev_frame_begin, ev_dat_wr;
    logic ev_scl_low_ctl, ev_sda_low_one;
    logic sw_wr, sw_start, sw_stop, sw_ack, sw_irq, irq_en;
    logic is_master, tx_dir, start_req, stop_req, ack_need, arb_fault, ack_bit, irq_flag, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [7:0] flags; // {is_master,tx_dir,start_req,stop_req,ack_need,arb_fault,ack_bit,irq_flag}
        logic       irq;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    smb_flag_ctrl u_smb_flag_ctrl (
        .clk(clk), .rst(rst),
        .ev_start_gen(ev_start_gen), .ev_stop_gen(ev_stop_gen),
        .ev_start_det(ev_start_det), .ev_stop_det(ev_stop_det),
        .ev_addr_match(ev_addr_match), .ev_byte_rx(ev_byte_rx),
        .ev_ack_cycle(ev_ack_cycle), .ack_line(ack_line),
        .ev_frame_begin(ev_frame_begin), .ev_dat_wr(ev_dat_wr),
        .ev_scl_low_ctl(ev_scl_low_ctl), .ev_sda_low_one(ev_sda_low_one),
        .sw_wr(sw_wr), .sw_start(sw_start), .sw_stop(sw_stop),
        .sw_ack(sw_ack), .sw_irq(sw_irq), .irq_en(irq_en),
        .is_master(is_master), .tx_dir(tx_dir), .start_req(start_req),
        .stop_req(stop_req), .ack_need(ack_need), .arb_fault(arb_fault),
        .ack_bit(ack_bit), .irq_flag(irq_flag), .irq(irq)
    );

    task automatic clear_inputs();
        ev_start_gen = 0; ev_stop_gen = 0; ev_start_det = 0; ev_stop_det = 0;
        ev_addr_match = 0; ev_byte_rx = 0; ev_ack_cycle = 0; ack_line = 1;
        ev_frame_begin = 0; ev_dat_wr = 0; ev_scl_low_ctl = 0; ev_sda_low_one = 0;
        sw_wr = 0; sw_start = 0; sw_stop = 0; sw_ack = 0; sw_irq = 0;
    endtask

    // Driver: push the expectation for the coming edge, then move to the next cycle
    task automatic cyc(input string tag, input logic [7:0] f, input logic i);
        exp_t e;
        e.tag = tag; e.flags = f; e.irq = i;
        exp_q.push_back(e);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic swr(input logic sta, input logic sto, input logic ack, input logic si);
        sw_wr = 1; sw_start = sta; sw_stop = sto; sw_ack = ack; sw_irq = si;
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            exp_t e;
            logic [7:0] act;
            e = exp_q.pop_front();
            act = {is_master, tx_dir, start_req, stop_req, ack_need, arb_fault, ack_bit, irq_flag};
            checks++;
            if (act !== e.flags || irq !== e.irq) begin
                failures++;
                $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                         e.tag, act, irq, e.flags, e.irq);
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst = 1; irq_en = 1;
        @(negedge clk);
        cyc("R1 reset", 8'b00000000, 0);
        cyc("R1 reset hold", 8'b00000000, 0);
        rst = 0;

        ev_start_gen = 1;                 cyc("R2 start generated", 8'b11000001, 1);
        swr(0,0,0,0);                     cyc("R9 sw clears irq_flag", 8'b11000000, 0);
        ev_ack_cycle = 1; ack_line = 0;   cyc("R11 ack low loads 1", 8'b11000011, 1);
        ev_ack_cycle = 1; ack_line = 1;   cyc("R11 ack high loads 0", 8'b11000001, 1);
        swr(0,0,0,0); irq_en = 0;         cyc("R13 cleared, disabled", 8'b11000000, 0);
        ev_frame_begin = 1;               cyc("R4 frame without write", 8'b10000000, 0);
        ev_ack_cycle = 1; ack_line = 0;   cyc("R11 ack cycle as receiver ignored", 8'b10000000, 0);
        ev_byte_rx = 1;                   cyc("R13 flag set but disabled", 8'b10001001, 0);
        irq_en = 1;                       cyc("R13 enable raises irq", 8'b10001001, 1);
        ev_byte_rx = 1; ev_ack_cycle = 1; cyc("R10 set beats ack clear", 8'b10001001, 1);
        ev_ack_cycle = 1;                 cyc("R10 ack cycle clears", 8'b10000001, 1);
        swr(0,1,1,1);                     cyc("R12 sw write", 8'b10010011, 1);
        ev_stop_gen = 1;                  cyc("R3 stop generated", 8'b00000011, 1);
        swr(0,0,0,0); ev_byte_rx = 1;     cyc("R12 hw set beats sw clear", 8'b00001001, 1);
        swr(0,1,0,1); ev_stop_gen = 1;    cyc("R12 sw beats hw clear", 8'b00011001, 1);
        swr(0,0,0,0); ev_ack_cycle = 1;   cyc("R10 cleanup", 8'b00000000, 0);

        ev_addr_match = 1;                cyc("R5 address match", 8'b00100001, 1);
        swr(1,0,0,0);                     cyc("R5 start_req kept", 8'b00100000, 0);
                                          cyc("R5 start_req idle hold", 8'b00100000, 0);
        ev_stop_det = 1;                  cyc("R6 stop while addressed", 8'b00110001, 1);
        swr(0,0,0,0);                     cyc("R6 cleanup", 8'b00000000, 0);
        ev_stop_det = 1;                  cyc("R6 stop not addressed ignored", 8'b00000000, 0);

        ev_dat_wr = 1;                    cyc("R4 data write", 8'b00000000, 0);
        ev_frame_begin = 1;               cyc("R4 frame after write", 8'b01000000, 0);
        ev_start_det = 1;                 cyc("R4 start detect clears tx", 8'b00000000, 0);

        ev_start_gen = 1;                 cyc("R2 start again", 8'b11000001, 1);
        swr(0,0,0,0);                     cyc("R9 clear", 8'b11000000, 0);
        ev_start_det = 1;                 cyc("R8 repeated start conflict", 8'b00000101, 1);
        swr(0,0,0,0);                     cyc("R9 fault clears with irq_flag", 8'b00000000, 0);

        ev_start_gen = 1;                 cyc("R2 start", 8'b11000001, 1);
        swr(0,0,0,0);                     cyc("R9 clear", 8'b11000000, 0);
        ev_scl_low_ctl = 1;               cyc("R8 scl low fault", 8'b00000101, 1);
        swr(0,0,0,1);                     cyc("R9 write 1 keeps fault", 8'b00000101, 1);
        swr(0,0,0,0);                     cyc("R9 clear", 8'b00000000, 0);

        ev_start_gen = 1;                 cyc("R2 start", 8'b11000001, 1);
        swr(0,0,0,0);                     cyc("R9 clear", 8'b11000000, 0);
        ev_sda_low_one = 1;               cyc("R8 sda low fault", 8'b00000101, 1);
        swr(0,0,0,0); ev_scl_low_ctl = 1; cyc("R12 fault beats clear", 8'b00000101, 1);
        swr(0,0,0,0);                     cyc("R9 clear", 8'b00000000, 0);

        ev_start_gen = 1;                 cyc("R2 start", 8'b11000001, 1);
        swr(0,0,0,0);                     cyc("R9 clear", 8'b11000000, 0);
        ev_stop_det = 1;                  cyc("R7 stop as master", 8'b00010001, 1);
        swr(0,0,0,0);                     cyc("R7 cleanup", 8'b00000000, 0);

        ev_start_gen = 1;                 cyc("R2 start", 8'b11000001, 1);
        swr(1,0,0,0);                     cyc("R5 sw sets start_req", 8'b11100000, 0);
        ev_start_det = 1;                 cyc("R8 own repeated start no fault", 8'b10100000, 0);
        ev_frame_begin = 1;               cyc("R4 frame no write", 8'b10100000, 0);
        ev_start_gen = 1;                 cyc("R2 start as master", 8'b11100001, 1);
        rst = 1;                          cyc("R1 reset mid-run", 8'b00000000, 0);
        rst = 0;

        @(posedge clk);
        #2;
        finished = 1;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule